// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the fetch address of a small 8-bit controller core and picks the next one every cycle. The address is 13 bits wide. The core sees only its low byte as a register. The upper bits come from a separate 5-bit page latch that software writes explicitly. Which latch bits reach the upper address depends on the kind of update. A write to the low byte takes all five latch bits. A jump or a call carries an 11-bit target and takes only the top two latch bits.

Calls save the address of the following instruction on an 8-entry circular return stack, and returns restore the full 13 bits from it. The stack never blocks. A ninth push overwrites the oldest entry, and a pop from an empty stack wraps the pointer. Each of these events raises a one-cycle status pulse. Instruction decoding, the ALU, program memory and interrupts live outside the block. The surrounding core drives one strobe per update source.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the fetch address, the page latch, the stack pointer and both status pulses to zero, whatever the strobes do.
- R2: With only `step_i` asserted the fetch address rises by one per cycle and wraps from 0x1FFF to 0x0000. With no strobe asserted it holds.
- R3: With `lowwr_i` selected the new address is {page[4:0], alu_i[7:0]}. The page value used is the one held before the edge, even if the page latch is written in the same cycle.
- R4: With `jump_i` selected the new address is {page[4:3], target_i[10:0]}.
- R5: With `call_i` selected the address loads as in R4. The incremented old address, wrapping at 0x1FFF, is written to the stack slot at the pointer, and the pointer rises by one modulo 8.
- R6: With `ret_i` selected the address loads from the slot at pointer minus one (modulo 8), and the pointer falls by one modulo 8.
- R7: When several strobes are high in one cycle, the priority is ret_i, then call_i, then jump_i, then lowwr_i, then step_i. Only the winner acts, so no push happens when a return wins.
- R8: The page latch changes only on `page_we_i`, taking `page_d_i`. It never takes bits from the address. `page_o` shows the latch and `pcl_o` shows address bits 7:0.
- R9: The stack holds 8 entries. A push made while 8 entries are held overwrites the oldest slot, and `ovf_o` is high for exactly the following cycle. The later pops return the 8 newest values, newest first.
- R10: A pop made while no entry is held still moves the pointer and returns the slot it reaches, and `unf_o` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Sequential advance |
| lowwr_i | input | 1 | ALU result written to the low address byte |
| jump_i | input | 1 | Absolute jump |
| call_i | input | 1 | Subroutine call |
| ret_i | input | 1 | Any return |
| alu_i | input | 8 | ALU result byte |
| target_i | input | 11 | Opcode address field |
| page_we_i | input | 1 | Page latch write enable |
| page_d_i | input | 5 | Page latch write data |
| fetch_addr_o | output | 13 | Current fetch address |
| pcl_o | output | 8 | Low address byte readback |
| page_o | output | 5 | Page latch readback |
| sp_o | output | 3 | Stack pointer (next free slot) |
| ovf_o | output | 1 | Overflow pulse, one cycle after an overwriting push |
| unf_o | output | 1 | Underflow pulse, one cycle after a pop from empty |

## Verification
The bench builds the block with its default parameters: a 13-bit address, a 5-bit page, an 11-bit target and an 8-deep stack. With a stack depth of 8, nine nested calls reach the overwrite case and nine returns reach the empty-pop case, all within a few dozen cycles. The 13-bit width lets a page of 0x1F with a low byte of 0xFF bring the address to the wrap point in a single step. A reference model in the bench follows every cycle of directed and random strobe mixes.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Which source produced the next fetch address
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOW  = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_CALL = 3'd4,
    SRC_RET  = 3'd5
  } src_e;

endpackage

// File: rtl/pcseq_page.sv
module pcseq_page #(
  parameter int LATCH_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [LATCH_W-1:0] d_i,
  output logic [LATCH_W-1:0] q_o
);

  logic [LATCH_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst)       page_q <= '0;
    else if (we_i) page_q <= d_i;
  end

  assign q_o = page_q;

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(page_q)); // R8
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (page_q == $past(d_i))); // R8

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic [W-1:0]             wdata_i,
  output logic [W-1:0]             top_o,
  output logic [$clog2(DEPTH)-1:0] ptr_o,
  output logic                     ovf_o,
  output logic                     unf_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_dn;
  logic [CNT_W-1:0] fill_q;
  logic             ovf_q, unf_q;
  logic [W-1:0]     ent [DEPTH];

  // Named events for the checks
  logic full_w, empty_w, push_w, pop_w;
  assign full_w  = (fill_q == CNT_W'(DEPTH));
  assign empty_w = (fill_q == '0);
  assign pop_w   = pop_i;
  assign push_w  = push_i && !pop_i;
  assign ptr_dn  = ptr_q - PTR_W'(1);

  // One register per slot, written when the pointer selects it
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                  ent[g] <= '0;
      else if (push_w && ptr_q == PTR_W'(g))    ent[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      fill_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      ovf_q <= push_w && full_w;
      unf_q <= pop_w && empty_w;
      if (pop_w) begin
        ptr_q <= ptr_dn;
        if (!empty_w) fill_q <= fill_q - CNT_W'(1);
      end else if (push_w) begin
        ptr_q <= ptr_q + PTR_W'(1);
        if (!full_w) fill_q <= fill_q + CNT_W'(1);
      end
    end
  end

  assign top_o = ent[ptr_dn];
  assign ptr_o = ptr_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  AST_PUSH_ADV: assert property (@(posedge clk) disable iff (rst)
    push_w |=> (ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)))); // R5
  AST_POP_BACK: assert property (@(posedge clk) disable iff (rst)
    pop_w |=> (ptr_q == PTR_W'($past(ptr_q) - PTR_W'(1)))); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> $past(push_i)); // R9
  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    unf_q |-> $past(pop_i)); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_q, unf_q})); // R9

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int LATCH_W = 5,
  parameter int JMP_W   = 11
) (
  input  logic               step_i,
  input  logic               lowwr_i,
  input  logic               jump_i,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [LATCH_W-1:0] page_i,
  input  logic [LO_W-1:0]    alu_i,
  input  logic [JMP_W-1:0]   target_i,
  input  logic [PC_W-1:0]    top_i,
  output logic [PC_W-1:0]    next_o,
  output logic [PC_W-1:0]    link_o,
  output src_e               src_o,
  output logic               push_o,
  output logic               pop_o
);

  localparam int HI_W  = PC_W - LO_W;
  localparam int SEG_W = PC_W - JMP_W;

  // Sequential successor, wrapping at the top of the address space
  function automatic logic [PC_W-1:0] f_incr(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  // Low-byte write: all page bits above the ALU byte
  function automatic logic [PC_W-1:0] f_lowwr(input logic [LATCH_W-1:0] pg,
                                              input logic [LO_W-1:0] b);
    return {pg[HI_W-1:0], b};
  endfunction

  // Jump or call: top page bits above the opcode field
  function automatic logic [PC_W-1:0] f_jump(input logic [LATCH_W-1:0] pg,
                                             input logic [JMP_W-1:0] t);
    return {pg[LATCH_W-1 -: SEG_W], t};
  endfunction

  always_comb begin
    if (ret_i)        src_o = SRC_RET;
    else if (call_i)  src_o = SRC_CALL;
    else if (jump_i)  src_o = SRC_JMP;
    else if (lowwr_i) src_o = SRC_LOW;
    else if (step_i)  src_o = SRC_INC;
    else              src_o = SRC_HOLD;
  end

  assign link_o = f_incr(pc_i);

  always_comb begin
    case (src_o)
      SRC_RET:             next_o = top_i;
      SRC_CALL, SRC_JMP:   next_o = f_jump(page_i, target_i);
      SRC_LOW:             next_o = f_lowwr(page_i, alu_i);
      SRC_INC:             next_o = link_o;
      default:             next_o = pc_i;
    endcase
  end

  assign push_o = (src_o == SRC_CALL);
  assign pop_o  = (src_o == SRC_RET);

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int LATCH_W = 5,
  parameter int JMP_W   = 11,
  parameter int DEPTH   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_i,
  input  logic                     lowwr_i,
  input  logic                     jump_i,
  input  logic                     call_i,
  input  logic                     ret_i,
  input  logic [LO_W-1:0]          alu_i,
  input  logic [JMP_W-1:0]         target_i,
  input  logic                     page_we_i,
  input  logic [LATCH_W-1:0]       page_d_i,
  output logic [PC_W-1:0]          fetch_addr_o,
  output logic [LO_W-1:0]          pcl_o,
  output logic [LATCH_W-1:0]       page_o,
  output logic [$clog2(DEPTH)-1:0] sp_o,
  output logic                     ovf_o,
  output logic                     unf_o
);

  localparam int HI_W  = PC_W - LO_W;
  localparam int SEG_W = PC_W - JMP_W;

  logic [PC_W-1:0]    pc_q;
  logic [PC_W-1:0]    pc_nxt;
  logic [PC_W-1:0]    link_w;
  logic [PC_W-1:0]    stk_top;
  logic [LATCH_W-1:0] page_q;
  logic               push_w, pop_w;
  src_e               src_w;

  pcseq_page #(.LATCH_W(LATCH_W)) u_page (
    .clk  (clk),
    .rst  (rst),
    .we_i (page_we_i),
    .d_i  (page_d_i),
    .q_o  (page_q)
  );

  pcseq_next #(
    .PC_W(PC_W), .LO_W(LO_W), .LATCH_W(LATCH_W), .JMP_W(JMP_W)
  ) u_next (
    .step_i   (step_i),
    .lowwr_i  (lowwr_i),
    .jump_i   (jump_i),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .pc_i     (pc_q),
    .page_i   (page_q),
    .alu_i    (alu_i),
    .target_i (target_i),
    .top_i    (stk_top),
    .next_o   (pc_nxt),
    .link_o   (link_w),
    .src_o    (src_w),
    .push_o   (push_w),
    .pop_o    (pop_w)
  );

  pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push_w),
    .pop_i   (pop_w),
    .wdata_i (link_w),
    .top_o   (stk_top),
    .ptr_o   (sp_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign fetch_addr_o = pc_q;
  assign pcl_o        = pc_q[LO_W-1:0];
  assign page_o       = page_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_q == '0 && page_q == '0 && sp_o == '0)); // R1
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (rst)
    (src_w == SRC_INC) |=> (pc_q == PC_W'($past(pc_q) + PC_W'(1)))); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src_w == SRC_HOLD) |=> $stable(pc_q)); // R2
  AST_LOW_PAGE: assert property (@(posedge clk) disable iff (rst)
    (src_w == SRC_LOW) |=> (pc_q[PC_W-1:LO_W] == $past(page_q[HI_W-1:0]))); // R3
  AST_JUMP_SEG: assert property (@(posedge clk) disable iff (rst)
    (jump_i && !call_i && !ret_i) |=>
      (pc_q[PC_W-1:JMP_W] == $past(page_q[LATCH_W-1 -: SEG_W]))); // R4
  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i) |-> (push_w && !pop_w)); // R5
  AST_RET_TOP: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> (pc_q == $past(stk_top))); // R6
  AST_RET_WINS: assert property (@(posedge clk) disable iff (rst)
    ret_i |-> !push_w); // R7

endmodule

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
module pc_sequencer_tb;

  typedef struct {
    logic [12:0] pc;
    logic [4:0]  page;
    logic [2:0]  sp;
    logic        ovf;
    logic        unf;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 0, lowwr_i = 0, jump_i = 0, call_i = 0, ret_i = 0;
  logic [7:0]  alu_i = '0;
  logic [10:0] target_i = '0;
  logic        page_we_i = 0;
  logic [4:0]  page_d_i = '0;
  logic [12:0] fetch_addr_o;
  logic [7:0]  pcl_o;
  logic [4:0]  page_o;
  logic [2:0]  sp_o;
  logic        ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  // reference model state
  logic [12:0] m_pc;
  logic [4:0]  m_page;
  logic [12:0] m_stk [8];
  int          m_sp, m_cnt;
  logic        m_ovf, m_unf;

  always #4 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .lowwr_i(lowwr_i), .jump_i(jump_i),
    .call_i(call_i), .ret_i(ret_i), .alu_i(alu_i), .target_i(target_i),
    .page_we_i(page_we_i), .page_d_i(page_d_i), .fetch_addr_o(fetch_addr_o),
    .pcl_o(pcl_o), .page_o(page_o), .sp_o(sp_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_page = '0; m_sp = 0; m_cnt = 0; m_ovf = 0; m_unf = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.pc = m_pc; e.page = m_page; e.sp = m_sp[2:0];
    e.ovf = m_ovf; e.unf = m_unf; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: applies one cycle, advances the model, queues the expected state
  task automatic drive(input bit r, input bit c, input bit j, input bit l, input bit s,
                       input logic [7:0] a, input logic [10:0] t,
                       input bit pw, input logic [4:0] pd, input string tag);
    logic [12:0] nxt;
    ret_i = r; call_i = c; jump_i = j; lowwr_i = l; step_i = s;
    alu_i = a; target_i = t; page_we_i = pw; page_d_i = pd;
    @(posedge clk);
    m_ovf = 0; m_unf = 0;
    if (r) begin
      m_sp = (m_sp + 7) % 8;
      nxt = m_stk[m_sp];
      if (m_cnt == 0) m_unf = 1; else m_cnt--;
    end else if (c) begin
      m_stk[m_sp] = (m_pc == 13'h1FFF) ? 13'h0 : m_pc + 13'd1;
      m_sp = (m_sp + 1) % 8;
      if (m_cnt == 8) m_ovf = 1; else m_cnt++;
      nxt = {m_page[4:3], t};
    end else if (j) begin
      nxt = {m_page[4:3], t};
    end else if (l) begin
      nxt = {m_page, a};
    end else if (s) begin
      nxt = (m_pc == 13'h1FFF) ? 13'h0 : m_pc + 13'd1;
    end else begin
      nxt = m_pc;
    end
    if (pw) m_page = pd;
    m_pc = nxt;
    push_exp(tag);
    @(negedge clk);
    ret_i = 0; call_i = 0; jump_i = 0; lowwr_i = 0; step_i = 0; page_we_i = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    // strobes active during reset must have no effect (R1)
    ret_i = 1; call_i = 1; step_i = 1; page_we_i = 1; page_d_i = 5'h1F;
    @(posedge clk);
    model_reset();
    push_exp("R1");
    @(negedge clk);
    rst = 1'b0;
    ret_i = 0; call_i = 0; step_i = 0; page_we_i = 0;
  endtask

  task automatic do_step(input string tag); drive(0,0,0,0,1,8'h00,11'h0,0,5'h0,tag); endtask
  task automatic do_hold(); drive(0,0,0,0,0,8'h00,11'h0,0,5'h0,"R2"); endtask
  task automatic do_page(input logic [4:0] p); drive(0,0,0,0,0,8'h00,11'h0,1,p,"R8"); endtask
  task automatic do_low(input logic [7:0] a); drive(0,0,0,1,0,a,11'h0,0,5'h0,"R3"); endtask
  task automatic do_jump(input logic [10:0] t); drive(0,0,1,0,0,8'h00,t,0,5'h0,"R4"); endtask
  task automatic do_call(input logic [10:0] t, input string tag); drive(0,1,0,0,0,8'h00,t,0,5'h0,tag); endtask
  task automatic do_ret(input string tag); drive(1,0,0,0,0,8'h00,11'h0,0,5'h0,tag); endtask

  // Monitor: compares each queued item against the ports away from the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "fetch_addr", fetch_addr_o, e.pc);
      check(e.tag, "pcl (R8)", pcl_o, e.pc[7:0]);
      check(e.tag, "page (R8)", page_o, e.page);
      check(e.tag, "sp", sp_o, e.sp);
      check(e.tag, "ovf (R9)", ovf_o, e.ovf);
      check(e.tag, "unf (R10)", unf_o, e.unf);
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();                                   // R1
    repeat (5) do_step("R2");                     // R2 increment
    do_hold(); do_hold();                         // R2 hold
    do_page(5'h15);                               // R8 page write
    do_low(8'h3C);                                // R3 -> 0x153C
    do_jump(11'h5A5);                             // R4 -> {2'b10,5A5}
    // R3: page written in the same cycle uses the old page
    drive(0,0,0,1,0,8'h77,11'h0,1,5'h0A,"R3");
    do_call(11'h123, "R5");                       // R5 push
    do_step("R2");
    do_ret("R6");                                 // R6 pop
    // R7 priority combinations
    do_call(11'h001, "R7");
    drive(1,1,1,1,1,8'hAA,11'h7FF,0,5'h0,"R7");   // return wins, no push
    drive(0,1,1,1,1,8'hAA,11'h2F0,0,5'h0,"R7");   // call wins
    drive(1,0,0,0,0,8'h00,11'h0,0,5'h0,"R7");
    drive(0,0,1,1,1,8'hAA,11'h3C3,0,5'h0,"R7");   // jump wins
    drive(0,0,0,1,1,8'h5E,11'h0,0,5'h0,"R7");     // low write wins
    // R2 wrap at the top of the space
    do_page(5'h1F);
    do_low(8'hFF);
    do_step("R2");
    do_step("R2");
    // R8: jumps do not feed the page latch
    do_page(5'h08);
    do_jump(11'h7FF);
    do_hold();
    // R9 overwrite after 8 entries, then R10 pop from empty
    do_reset();
    for (int i = 0; i < 9; i++) do_call(11'h100 + 11'(i * 3), "R9");
    do_step("R9");
    for (int i = 0; i < 8; i++) do_ret("R9");
    do_ret("R10");
    do_hold();
    do_ret("R10");
    // call from 0x1FFF pushes 0x0000 (R5 wrap)
    do_reset();
    do_page(5'h1F);
    do_low(8'hFF);
    do_call(11'h010, "R5");
    do_ret("R5");
    // random mixes against the model
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0,5) == 0, $urandom_range(0,5) == 0, $urandom_range(0,4) == 0,
            $urandom_range(0,4) == 0, $urandom_range(0,1) == 1,
            8'($urandom), 11'($urandom), $urandom_range(0,6) == 0, 5'($urandom), "R7");
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule